// File: doc/BRIEF.md
# Write-Back MSI Snooping Cache Node

This block is the per-node controller of a small direct-mapped, write-back cache that sits on a shared, atomic snooping bus. Every line is in one of three states. Invalid holds nothing. Shared holds a clean, read-only copy that matches memory. Exclusive holds the only copy, which may be written and is dirty. Processor reads and writes are served from the line array when the line's state allows it. In every other case the node asks for the bus and issues a read miss or a write miss. When the line it must replace is dirty and belongs to another block, it first issues a write-back of that block.

The node also watches the transactions that other nodes place on the bus. If another node's miss names a block that this node holds dirty, the node supplies the block on its snoop data output in the same cycle and raises an abort line. Memory must then stay off the bus and take the supplied value as a write-back. A write miss from another node removes any copy held here. A read miss from another node turns a dirty copy into a clean shared one.

Each block is one data word. The low address bits select the line and the remaining bits form the tag. A processor request is a one-cycle pulse, and it is completed by a one-cycle `cpu_done` pulse. The bus is granted one transaction at a time, and a node's transaction occupies exactly one granted cycle.

Top module: `msi_snoop_node`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses, and `bus_req`, `cpu_done` and `snp_abort` are low.
- R2: A processor read to an invalid line issues one read miss (`bus_cmd` = 1), returns the bus data on `cpu_rdata` with `cpu_done` in the cycle after the granted cycle, and leaves the line shared.
- R3: A processor write to an invalid line, or to a shared line, is treated as a miss: it issues one write miss (`bus_cmd` = 2), completes with the written value on `cpu_rdata`, and leaves the line exclusive.
- R4: A read that hits a shared or exclusive line, or a write that hits an exclusive line, raises no bus request and completes one cycle after the request.
- R5: A miss whose line is exclusive under another tag first issues a write-back (`bus_cmd` = 3) carrying that block's full address and data, then the miss. The write-back alone never completes the request.
- R6: A miss whose line is shared under another tag issues the miss at once, with no write-back. A read leaves the line shared; a write leaves it exclusive.
- R7: A snooped write miss to a block held shared invalidates the line without raising `snp_abort`.
- R8: A snooped read miss to a block held exclusive raises `snp_abort` and drives the block's data on `snp_data` in that same cycle, and the line becomes shared. This holds even when the snoop arrives in the cycle of a processor request to that line, or while the node waits for a grant to write the line back; in the latter case no write-back follows.
- R9: A snooped write miss to a block held exclusive raises `snp_abort` with the block's data and invalidates the line.
- R10: Snooped write-backs, idle cycles, and misses to blocks not held (another tag on the same line, or an invalid line) raise no abort and leave the lines unchanged.
- R11: Command codes are 0 idle, 1 read miss, 2 write miss, 3 write-back. `bus_cmd` is non-idle only in a cycle with both `bus_req` and `bus_gnt` high, and the node holds `bus_req` while it waits for a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle processor request pulse, raised only when no request is outstanding |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, or the written value for a write, valid with `cpu_done` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Grant for the current cycle |
| bus_cmd | output | 2 | Command driven in the granted cycle |
| bus_addr | output | ADDR_W | Address of the driven command |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data for this node's read miss, valid in the granted cycle |
| snp_cmd | input | 2 | Command of another node's transaction |
| snp_addr | input | ADDR_W | Address of another node's transaction |
| snp_abort | output | 1 | Node holds the snooped block dirty; memory must not respond |
| snp_data | output | DATA_W | Block supplied with `snp_abort`, zero otherwise |

## Verification
A wrong line state is not visible at once. It shows at the next access to the same line: as a missing or extra bus command on the next processor access, or as a missing or extra abort on the next snoop. The bench therefore follows each state-changing event with a processor access or a snoop that tells the states apart. A wrong transition on the processor side appears one cycle after the request, as a bus request that should not be there or as a missing `cpu_done`. A wrong transition after a snoop appears on the first later transaction that touches that line.

// File: rtl/msi_node_pkg.sv
`timescale 1ns/1ps
package msi_node_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_RDMISS = 2'd1,
        CMD_WRMISS = 2'd2,
        CMD_WRBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        C_IDLE   = 2'd0,
        C_VICTIM = 2'd1,
        C_MISS   = 2'd2
    } ctrl_st_e;
endpackage

// File: rtl/msi_line_array.sv
`timescale 1ns/1ps
module msi_line_array
    import msi_node_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_st,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_st,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_st_e          s_st,
    input  logic              c_we,
    input  logic [IDX_W-1:0]  c_idx,
    input  line_st_e          c_st,
    input  logic [TAG_W-1:0]  c_tag,
    input  logic [DATA_W-1:0] c_data
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_q   [LINES];
    line_st_e          st_d   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [DATA_W-1:0] data_d [LINES];

    assign ra_st   = st_q[ra_idx];
    assign ra_tag  = tag_q[ra_idx];
    assign ra_data = data_q[ra_idx];
    assign rb_st   = st_q[rb_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign rb_data = data_q[rb_idx];

    // Snoop update first; the processor-side update is computed on the
    // post-snoop view, so it takes precedence on the same line.
    always_comb begin
        st_d   = st_q;
        tag_d  = tag_q;
        data_d = data_q;
        if (s_we) st_d[s_idx] = s_st;
        if (c_we) begin
            st_d[c_idx]   = c_st;
            tag_d[c_idx]  = c_tag;
            data_d[c_idx] = c_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        data_q <= data_d;
    end
endmodule

// File: rtl/msi_snoop_resp.sv
`timescale 1ns/1ps
module msi_snoop_resp
    import msi_node_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  bus_cmd_e          cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              chg,
    output line_st_e          nst,
    output logic              abort,
    output logic [DATA_W-1:0] data
);
    logic match;
    assign match = (ln_st != LN_INV) && (ln_tag == snp_tag);

    always_comb begin
        chg   = 1'b0;
        nst   = ln_st;
        abort = 1'b0;
        if (match) begin
            unique case (cmd)
                CMD_RDMISS: if (ln_st == LN_EXC) begin
                    chg   = 1'b1;
                    nst   = LN_SHR;
                    abort = 1'b1;
                end
                CMD_WRMISS: begin
                    chg   = 1'b1;
                    nst   = LN_INV;
                    abort = (ln_st == LN_EXC);
                end
                default: ;
            endcase
        end
    end

    assign data = abort ? ln_data : '0;
endmodule

// File: rtl/msi_snoop_node.sv
`timescale 1ns/1ps
module msi_snoop_node
    import msi_node_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctrl_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t q, d;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    line_st_e          ra_st, rb_st, post_st, s_nst, c_st;
    logic [TAG_W-1:0]  ra_tag, rb_tag, c_tag;
    logic [DATA_W-1:0] ra_data, rb_data, c_data;
    logic              s_chg, c_we, hit;
    bus_cmd_e          cmd_c;

    assign cpu_idx = (q.st == C_IDLE) ? cpu_addr[IDX_W-1:0]      : q.addr[IDX_W-1:0];
    assign cpu_tag = (q.st == C_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : q.addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(cpu_idx), .ra_st(ra_st), .ra_tag(ra_tag), .ra_data(ra_data),
        .rb_idx(snp_idx), .rb_st(rb_st), .rb_tag(rb_tag), .rb_data(rb_data),
        .s_we(s_chg), .s_idx(snp_idx), .s_st(s_nst),
        .c_we(c_we), .c_idx(cpu_idx), .c_st(c_st), .c_tag(c_tag), .c_data(c_data)
    );

    msi_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .cmd(bus_cmd_e'(snp_cmd)), .snp_tag(snp_tag),
        .ln_st(rb_st), .ln_tag(rb_tag), .ln_data(rb_data),
        .chg(s_chg), .nst(s_nst), .abort(snp_abort), .data(snp_data)
    );

    // Processor side sees the line as it stands after this cycle's snoop.
    assign post_st = (s_chg && (snp_idx == cpu_idx)) ? s_nst : ra_st;
    assign hit     = (post_st != LN_INV) && (ra_tag == cpu_tag);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        c_we      = 1'b0;
        c_st      = LN_INV;
        c_tag     = cpu_tag;
        c_data    = ra_data;
        bus_req   = 1'b0;
        cmd_c     = CMD_IDLE;
        bus_addr  = q.addr;
        bus_wdata = q.wdata;
        unique case (q.st)
            C_IDLE: if (cpu_req) begin
                d.addr  = cpu_addr;
                d.we    = cpu_we;
                d.wdata = cpu_wdata;
                if (hit && (!cpu_we || post_st == LN_EXC)) begin
                    d.done  = 1'b1;
                    d.rdata = cpu_we ? cpu_wdata : ra_data;
                    if (cpu_we) begin
                        c_we   = 1'b1;
                        c_st   = LN_EXC;
                        c_data = cpu_wdata;
                    end
                end else if (post_st == LN_EXC) begin
                    d.st = C_VICTIM;       // dirty block of another tag
                end else begin
                    d.st = C_MISS;
                end
            end
            C_VICTIM: begin
                if (post_st != LN_EXC) begin
                    d.st = C_MISS;         // a snoop already took the victim
                end else begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        cmd_c     = CMD_WRBACK;
                        bus_addr  = {ra_tag, cpu_idx};
                        bus_wdata = ra_data;
                        c_we      = 1'b1;
                        c_st      = LN_SHR;
                        c_tag     = ra_tag;
                        d.st      = C_MISS;
                    end
                end
            end
            C_MISS: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    cmd_c   = q.we ? CMD_WRMISS : CMD_RDMISS;
                    c_we    = 1'b1;
                    c_st    = q.we ? LN_EXC : LN_SHR;
                    c_data  = q.we ? q.wdata : bus_rdata;
                    d.done  = 1'b1;
                    d.rdata = c_data;
                    d.st    = C_IDLE;
                end
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= C_IDLE;
            q.addr  <= '0;
            q.we    <= 1'b0;
            q.wdata <= '0;
            q.done  <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_cmd   = cmd_c;
    assign cpu_done  = q.done;
    assign cpu_rdata = q.rdata;

    // R11: a command is driven only in a requested and granted cycle
    p_cmd_granted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0) |-> (bus_req && bus_gnt));

    // R2 / R3: a miss transaction completes the request one cycle later
    p_miss_completes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd1 || bus_cmd == 2'd2) |=> cpu_done);

    // R5: a write-back is followed by a pending miss, never by completion
    p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd3) |=> (bus_req && !cpu_done));

    // R10: intervention only answers another node's miss
    p_abort_on_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> (snp_cmd == 2'd1 || snp_cmd == 2'd2));
endmodule

// File: tb/msi_snoop_node_tb.sv
`timescale 1ns/1ps
module msi_snoop_node_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_req, cpu_we, cpu_done;
    logic [7:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic       bus_req, bus_gnt;
    logic [1:0] bus_cmd, snp_cmd;
    logic [7:0] bus_addr, bus_wdata, bus_rdata, snp_addr, snp_data;
    logic       snp_abort;
    logic [7:0] mem [256];
    int         n_chk = 0;
    int         n_err = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_rdata = mem[bus_addr];

    msi_snoop_node u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_abort(snp_abort), .snp_data(snp_data)
    );

    typedef struct packed {
        logic       cpu;  logic       we;   logic [7:0] a;    logic [7:0] wd;
        logic [1:0] sc;   logic [7:0] sa;
        logic       xwb;  logic [7:0] xwba; logic [1:0] xmc;  logic [7:0] xrd;
        logic       xab;  logic [7:0] xsd;  logic [7:0] rq;
    } vec_t;

    // Memory word at address a starts as a ^ 8'h5A. Codes: 1 rd miss, 2 wr miss, 3 write-back.
    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{1,0,'h04,'h00,0,'h00, 0,'h00,1,'h5E, 0,'h00, 2 },  // R2 read invalid
        '{1,0,'h04,'h00,0,'h00, 0,'h00,0,'h5E, 0,'h00, 4 },  // R4 read hit shared
        '{1,1,'h04,'h11,0,'h00, 0,'h00,2,'h11, 0,'h00, 3 },  // R3 write to shared
        '{1,1,'h04,'h22,0,'h00, 0,'h00,0,'h22, 0,'h00, 4 },  // R4 write hit exclusive
        '{1,0,'h08,'h00,0,'h00, 1,'h04,1,'h52, 0,'h00, 5 },  // R5 dirty victim, read
        '{1,0,'h0C,'h00,0,'h00, 0,'h00,1,'h56, 0,'h00, 6 },  // R6 shared victim, read
        '{1,1,'h10,'h33,0,'h00, 0,'h00,2,'h33, 0,'h00, 6 },  // R6 shared victim, write
        '{1,1,'h14,'h44,0,'h00, 1,'h10,2,'h44, 0,'h00, 5 },  // R5 dirty victim, write
        '{0,0,'h00,'h00,1,'h14, 0,'h00,0,'h00, 1,'h44, 8 },  // R8 snoop read, dirty
        '{0,0,'h00,'h00,1,'h14, 0,'h00,0,'h00, 0,'h00, 8 },  // R8 now shared
        '{1,0,'h14,'h00,0,'h00, 0,'h00,0,'h44, 0,'h00, 8 },  // R8 still readable
        '{1,1,'h14,'h55,0,'h00, 0,'h00,2,'h55, 0,'h00, 8 },  // R8 write needs miss
        '{0,0,'h00,'h00,2,'h14, 0,'h00,0,'h00, 1,'h55, 9 },  // R9 snoop write, dirty
        '{1,0,'h14,'h00,0,'h00, 0,'h00,1,'h55, 0,'h00, 9 },  // R9 line invalid
        '{0,0,'h00,'h00,2,'h14, 0,'h00,0,'h00, 0,'h00, 7 },  // R7 snoop write, shared
        '{1,0,'h14,'h00,0,'h00, 0,'h00,1,'h55, 0,'h00, 7 },  // R7 line invalid
        '{0,0,'h00,'h00,1,'h18, 0,'h00,0,'h00, 0,'h00, 10},  // R10 other tag
        '{1,0,'h14,'h00,0,'h00, 0,'h00,0,'h55, 0,'h00, 10},  // R10 unchanged
        '{1,1,'h01,'h66,0,'h00, 0,'h00,2,'h66, 0,'h00, 3 },  // R3 write invalid
        '{0,0,'h00,'h00,3,'h01, 0,'h00,0,'h00, 0,'h00, 10},  // R10 snooped write-back
        '{0,0,'h00,'h00,1,'h05, 0,'h00,0,'h00, 0,'h00, 10},  // R10 other tag, dirty line
        '{1,0,'h01,'h00,0,'h00, 0,'h00,0,'h66, 0,'h00, 10},  // R10 dirty line kept
        '{1,0,'h14,'h00,0,'h00, 0,'h00,0,'h55, 0,'h00, 4 },  // R4 other line untouched
        '{1,0,'h04,'h00,0,'h00, 0,'h00,1,'h22, 0,'h00, 5 }   // R5 written-back data
    };

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input logic cen, input logic we, input logic [7:0] a, input logic [7:0] wd,
                         input logic [1:0] sc, input logic [7:0] sa, input int snp_at, input int hold,
                         output logic wb, output logic [7:0] wba, output logic [1:0] mc,
                         output logic [7:0] rd, output logic ab, output logic [7:0] sd);
        wb = 0; wba = 0; mc = 0; rd = 0; ab = 0; sd = 0;
        @(negedge clk);
        cpu_req = cen; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (snp_at == 0) begin
            snp_cmd = sc; snp_addr = sa;
            #1;
            ab = snp_abort; sd = snp_data;
            if (ab) mem[sa] = sd;
        end
        @(negedge clk);
        cpu_req = 1'b0; snp_cmd = 2'd0;
        if (cen) begin
            for (int i = 0; i < 30; i++) begin
                bus_gnt = 1'b0; snp_cmd = 2'd0;
                if (cpu_done) begin
                    rd = cpu_rdata;
                    break;
                end
                if (bus_req) begin
                    if (i == 0 && snp_at == 1) begin
                        snp_cmd = sc; snp_addr = sa;
                        #1;
                        ab = snp_abort; sd = snp_data;
                        if (ab) mem[sa] = sd;
                    end else if (i < hold) begin
                        #1;
                        check("R11", "command while not granted", bus_cmd, 0);
                    end else begin
                        bus_gnt = 1'b1;
                        #1;
                        if (bus_cmd == 2'd3) begin
                            wb = 1'b1; wba = bus_addr; mem[bus_addr] = bus_wdata;
                        end else begin
                            mc = bus_cmd;
                        end
                    end
                end
                @(negedge clk);
            end
        end
        bus_gnt = 1'b0; snp_cmd = 2'd0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic       wb, ab;
        logic [7:0] wba, rd, sd;
        logic [1:0] mc;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        bus_gnt = 0; snp_cmd = 0; snp_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        snp_cmd = 2'd1; snp_addr = 8'h04;
        #1;
        check("R1", "bus_req after reset", bus_req, 0);
        check("R1", "cpu_done after reset", cpu_done, 0);
        check("R1", "abort after reset", snp_abort, 0);
        snp_cmd = 2'd0;

        for (int k = 0; k < NV; k++) begin
            string rq;
            rq = $sformatf("R%0d", TBL[k].rq);
            do_op(TBL[k].cpu, TBL[k].we, TBL[k].a, TBL[k].wd, TBL[k].sc, TBL[k].sa, 0, 0,
                  wb, wba, mc, rd, ab, sd);
            if (TBL[k].cpu) begin
                check(rq, $sformatf("vec %0d write-back", k), wb, TBL[k].xwb);
                if (TBL[k].xwb) check(rq, $sformatf("vec %0d wb addr", k), wba, TBL[k].xwba);
                check(rq, $sformatf("vec %0d miss cmd", k), mc, TBL[k].xmc);
                check(rq, $sformatf("vec %0d rdata", k), rd, TBL[k].xrd);
            end else begin
                check(rq, $sformatf("vec %0d abort", k), ab, TBL[k].xab);
                if (TBL[k].xab) check(rq, $sformatf("vec %0d snoop data", k), sd, TBL[k].xsd);
            end
        end

        // R1: reset drops the dirty line at index 1; memory still holds 01^5A
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_op(1, 0, 8'h01, 8'h00, 0, 8'h00, 0, 0, wb, wba, mc, rd, ab, sd);
        check("R1", "miss after reset", mc, 1);
        check("R1", "no write-back after reset", wb, 0);
        check("R1", "data after reset", rd, 8'h5B);

        // R8: snoop read in the same cycle as a write that would hit exclusive
        do_op(1, 1, 8'h02, 8'h77, 0, 8'h00, 0, 0, wb, wba, mc, rd, ab, sd);
        check("R3", "write miss to invalid", mc, 2);
        do_op(1, 1, 8'h02, 8'h88, 2'd1, 8'h02, 0, 0, wb, wba, mc, rd, ab, sd);
        check("R8", "same-cycle abort", ab, 1);
        check("R8", "same-cycle snoop data", sd, 8'h77);
        check("R8", "write now misses", mc, 2);
        check("R8", "no write-back", wb, 0);

        // R8/R5: snoop takes the dirty victim while the node waits for a grant
        do_op(1, 0, 8'h06, 8'h00, 2'd1, 8'h02, 1, 3, wb, wba, mc, rd, ab, sd);
        check("R8", "abort while waiting", ab, 1);
        check("R8", "victim data supplied", sd, 8'h88);
        check("R5", "write-back skipped", wb, 0);
        check("R2", "read miss issued", mc, 1);
        check("R2", "fill data", rd, 8'h5C);
        do_op(1, 0, 8'h02, 8'h00, 0, 8'h00, 0, 0, wb, wba, mc, rd, ab, sd);
        check("R6", "conflict shared read", mc, 1);
        check("R8", "supplied value reached memory", rd, 8'h88);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule